// File: doc/BRIEF.md
# Transmit Clock Failover Selector

This block picks the clock that drives one E1 transmit port. Normally the port runs from a primary clock. That clock is either the dedicated transmit clock input, nominally 2.048 MHz, or, when the derived mode is on, the system clock divided by 2, 4 or 8. An activity monitor watches the primary clock and both backup clocks from a separate free-running monitoring clock. When the primary goes quiet, the output moves to whichever backup the host has chosen: the system reference clock or the port's recovered receive clock.

The host can also force the output onto the chosen backup at any time. The output returns to the primary only once the primary has been seen running again and no force is held. Every change of source goes through a handshake multiplexer, so no runt pulse reaches the output. A sticky interrupt flag reports loss of the primary clock. The host clears it with a write-one-to-clear pulse and can mask it with an enable bit.

Top module: `txclk_failover`

## Requirements
- R1: A watched clock is flagged lost once it shows no edge for LOSS_CYCLES (default 32) consecutive monitoring-clock cycles. A clock whose gaps between edges stay well below that limit is never flagged.
- R2: A lost flag clears after RECOVER_EDGES (default 32) further edges of that clock, each arriving before the quiet limit is reached again.
- R3: While the primary is lost, the output runs from the backup chosen by backup_sel (0 = reference clock, 1 = recovered clock). status[1:0] reports the active source as 0 = primary, 1 = reference, 2 = recovered.
- R4: While force_sw is high, the output runs from the chosen backup whatever the state of the primary.
- R5: The output returns to the primary once the primary's lost flag has cleared and force_sw is low.
- R6: With div_mode high, the primary is sys_clk divided by 2, 4 or 8 for div_sel 00, 01 or 10 (11 also gives 8), and tx_clk_in has no effect.
- R7: With div_mode high, loss of sys_clk makes the primary lost and triggers the same failover as in R3.
- R8: status[5] is a sticky flag. It sets on the rising edge of the primary lost flag, stays set after the primary recovers, and clears on an irq_clr pulse. Loss of a backup clock does not set it.
- R9: irq equals status[5] gated by irq_en.
- R10: At most one source is gated onto clk_out at a time. A switch between two running sources produces no high or low pulse shorter than the smaller of their half periods.
- R11: status[2], status[3] and status[4] are the lost flags of the primary, reference and recovered clocks.
- R12: While rst_n is low, status is all zeros and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mon | input | 1 | Free-running monitoring clock; host controls are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk_in | input | 1 | Dedicated primary transmit clock |
| sys_clk | input | 1 | System clock, divided in derived mode |
| ref_clk | input | 1 | System reference clock, backup 0 |
| rec_clk | input | 1 | Port's recovered clock, backup 1 |
| div_mode | input | 1 | 1 = primary derived from divided sys_clk |
| div_sel | input | 2 | Divider choice: 00 /2, 01 /4, 10 and 11 /8 |
| backup_sel | input | 1 | Backup choice: 0 reference, 1 recovered |
| force_sw | input | 1 | Hold the output on the chosen backup |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for the sticky flag |
| clk_out | output | 1 | Selected transmit clock |
| status | output | 6 | {irq flag, rec lost, ref lost, primary lost, active source[1:0]} |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong monitor count shows up on the lost bits of status. The bit either rises while the clock is still running or is still clear well after the clock has stopped, a few tens of monitoring cycles later. A wrong source decision appears in status[1:0] one monitoring cycle after the cause. It also appears on clk_out within a few source periods as an edge rate that matches the wrong clock. A broken handshake state shows as a runt pulse or a stuck output during a forced switch. A lost interrupt edge shows as status[5] staying clear after the primary has stopped.

// File: rtl/txcs_pkg.sv
package txcs_pkg;
   localparam int unsigned NUM_SRC = 3;
   typedef enum logic [1:0] {
      SRC_PRI = 2'd0,
      SRC_REF = 2'd1,
      SRC_REC = 2'd2
   } src_e;
endpackage

// File: rtl/txcs_sysdiv.sv
module txcs_sysdiv #(
   parameter int unsigned DIV_STEPS = 3
) (
   input  logic       sys_clk,
   input  logic       rst_n,
   input  logic [1:0] div_sel,
   output logic       div_clk
);
   generate
      if (DIV_STEPS < 1) begin : g_bad_steps
         $error("DIV_STEPS must be at least 1");
      end
   endgenerate

   logic [DIV_STEPS-1:0] cnt_q;
   int unsigned          tap;

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   // each counter bit is a registered square wave; a static tap is glitch free
   always_comb begin
      tap = (int'(div_sel) >= DIV_STEPS - 1) ? DIV_STEPS - 1 : int'(div_sel);
      div_clk = cnt_q[tap];
   end
endmodule

// File: rtl/txcs_actmon.sv
module txcs_actmon #(
   parameter int unsigned LOSS_CYCLES   = 32,
   parameter int unsigned RECOVER_EDGES = 32,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk_mon,
   input  logic rst_n,
   input  logic watched_clk,
   output logic lost
);
   localparam int unsigned QW = $clog2(LOSS_CYCLES + 1);
   localparam int unsigned GW = $clog2(RECOVER_EDGES + 1);

   logic                 tog_q;
   logic [SYNC_STAGES:0] sync_q;
   logic                 edge_seen;
   logic                 quiet_hit;
   logic [QW-1:0]        quiet_q;
   logic [GW-1:0]        good_q;
   logic                 lost_q;

   always_ff @(posedge watched_clk or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= ~tog_q;
   end

   always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], tog_q};
   end

   assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
   assign quiet_hit = !edge_seen && (quiet_q == QW'(LOSS_CYCLES - 1));

   always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= '0;
         good_q  <= '0;
         lost_q  <= 1'b0;
      end else begin
         if (edge_seen)                          quiet_q <= '0;
         else if (quiet_q != QW'(LOSS_CYCLES))   quiet_q <= quiet_q + 1'b1;

         if (!lost_q || quiet_hit)  good_q <= '0;
         else if (edge_seen)        good_q <= good_q + 1'b1;

         if (quiet_hit)
            lost_q <= 1'b1;
         else if (lost_q && edge_seen && good_q == GW'(RECOVER_EDGES - 1))
            lost_q <= 1'b0;
      end
   end

   assign lost = lost_q;

   p_edge_blocks_loss_r1: assert property (@(posedge clk_mon) disable iff (!rst_n)
      edge_seen |=> !$rose(lost_q));
   p_quiet_blocks_recover_r2: assert property (@(posedge clk_mon) disable iff (!rst_n)
      !edge_seen |=> !$fell(lost_q));
endmodule

// File: rtl/txcs_gfmux.sv
module txcs_gfmux #(
   parameter int unsigned NUM = 3
) (
   input  logic                   clk_mon,
   input  logic                   rst_n,
   input  logic [NUM-1:0]         clk_in,
   input  logic [NUM-1:0]         kill,
   input  logic [$clog2(NUM)-1:0] sel,
   output logic                   clk_out
);
   localparam int unsigned  SEL_W = $clog2(NUM);
   localparam logic [NUM-1:0] ONE = 1;

   generate
      if (NUM < 2) begin : g_bad_num
         $error("NUM must be at least 2");
      end
   endgenerate

   logic [NUM-1:0] en_neg;
   logic [NUM-1:0] gated;

   for (genvar i = 0; i < NUM; i++) begin : g_ch
      logic ch_rst_n, req, en_p_q, en_n_q;
      assign ch_rst_n = rst_n & ~kill[i];
      assign req = (sel == SEL_W'(i)) && !(|(en_neg & ~(ONE << i)));

      always_ff @(posedge clk_in[i] or negedge ch_rst_n) begin
         if (!ch_rst_n) en_p_q <= 1'b0;
         else           en_p_q <= req;
      end
      always_ff @(negedge clk_in[i] or negedge ch_rst_n) begin
         if (!ch_rst_n) en_n_q <= 1'b0;
         else           en_n_q <= en_p_q;
      end

      assign en_neg[i] = en_n_q;
      assign gated[i]  = clk_in[i] & en_n_q;
   end

   assign clk_out = |gated;

   p_one_source_r10: assert property (@(posedge clk_mon) disable iff (!rst_n)
      $onehot0(en_neg));
endmodule

// File: rtl/txclk_failover.sv
module txclk_failover
   import txcs_pkg::*;
#(
   parameter int unsigned LOSS_CYCLES   = 32,
   parameter int unsigned RECOVER_EDGES = 32,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned DIV_STEPS     = 3
) (
   input  logic       clk_mon,
   input  logic       rst_n,
   input  logic       tx_clk_in,
   input  logic       sys_clk,
   input  logic       ref_clk,
   input  logic       rec_clk,
   input  logic       div_mode,
   input  logic [1:0] div_sel,
   input  logic       backup_sel,
   input  logic       force_sw,
   input  logic       irq_en,
   input  logic       irq_clr,
   output logic       clk_out,
   output logic [5:0] status,
   output logic       irq
);
   generate
      if (LOSS_CYCLES < 4) begin : g_bad_loss
         $error("LOSS_CYCLES must be at least 4");
      end
      if (RECOVER_EDGES < 1) begin : g_bad_rec
         $error("RECOVER_EDGES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic               div_clk;
   logic               pri_clk;
   logic [NUM_SRC-1:0] src_clk;
   logic [NUM_SRC-1:0] lost;
   logic [NUM_SRC-1:0] kill_q;
   src_e               sel_q, sel_d;
   logic               pri_lost_d;
   logic               irq_flag;

   txcs_sysdiv #(.DIV_STEPS(DIV_STEPS)) u_div (
      .sys_clk(sys_clk), .rst_n(rst_n), .div_sel(div_sel), .div_clk(div_clk));

   // mode is static configuration; this selects the primary before monitoring
   assign pri_clk = div_mode ? div_clk : tx_clk_in;
   assign src_clk = {rec_clk, ref_clk, pri_clk};

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_mon
      txcs_actmon #(
         .LOSS_CYCLES(LOSS_CYCLES), .RECOVER_EDGES(RECOVER_EDGES), .SYNC_STAGES(SYNC_STAGES)
      ) u_mon (
         .clk_mon(clk_mon), .rst_n(rst_n), .watched_clk(src_clk[i]), .lost(lost[i]));
   end

   always_comb begin
      if (force_sw || lost[SRC_PRI]) sel_d = backup_sel ? SRC_REC : SRC_REF;
      else                           sel_d = SRC_PRI;
   end

   always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n) begin
         sel_q      <= SRC_PRI;
         pri_lost_d <= 1'b0;
         irq_flag   <= 1'b0;
         kill_q     <= '0;
      end else begin
         sel_q      <= sel_d;
         pri_lost_d <= lost[SRC_PRI];
         if (lost[SRC_PRI] && !pri_lost_d) irq_flag <= 1'b1;
         else if (irq_clr)                 irq_flag <= 1'b0;
         for (int i = 0; i < NUM_SRC; i++)
            kill_q[i] <= lost[i] && (sel_q != src_e'(i));
      end
   end

   txcs_gfmux #(.NUM(NUM_SRC)) u_mux (
      .clk_mon(clk_mon), .rst_n(rst_n), .clk_in(src_clk), .kill(kill_q),
      .sel(sel_q), .clk_out(clk_out));

   assign status = {irq_flag, lost, sel_q};
   assign irq    = irq_flag & irq_en;

   p_failover_ref_r3: assert property (@(posedge clk_mon) disable iff (!rst_n)
      (lost[SRC_PRI] && !backup_sel) |=> sel_q == SRC_REF);
   p_force_backup_r4: assert property (@(posedge clk_mon) disable iff (!rst_n)
      force_sw |=> sel_q != SRC_PRI);
   p_return_primary_r5: assert property (@(posedge clk_mon) disable iff (!rst_n)
      (!force_sw && !lost[SRC_PRI]) |=> sel_q == SRC_PRI);
   p_irq_sets_r8: assert property (@(posedge clk_mon) disable iff (!rst_n)
      $rose(lost[SRC_PRI]) |=> irq_flag);
endmodule

// File: tb/txclk_failover_bench.sv
`timescale 1ns/1ps
module txclk_failover_bench;
   logic clk_mon = 1'b0, rst_n = 1'b0;
   logic tclk = 1'b0, sys_clk = 1'b0, ref_clk = 1'b0, rec_clk = 1'b0;
   logic tclk_run = 1'b1, sys_run = 1'b1, ref_run = 1'b1;
   logic div_mode = 1'b0, backup_sel = 1'b0, force_sw = 1'b0;
   logic irq_en = 1'b1, irq_clr = 1'b0;
   logic [1:0] div_sel = 2'd0;
   logic       clk_out, irq;
   logic [5:0] status;

   int checks = 0, errors = 0;
   int edge_cnt = 0;
   logic counting = 1'b0, meas = 1'b0;
   realtime last_t = 0.0, min_w = 1.0e9;

   always #2  clk_mon = ~clk_mon;
   always #10 if (tclk_run) tclk = ~tclk;
   always #3  if (sys_run)  sys_clk = ~sys_clk;
   always #14 if (ref_run)  ref_clk = ~ref_clk;
   always #18 rec_clk = ~rec_clk;

   txclk_failover u_txclk_failover (
      .clk_mon(clk_mon), .rst_n(rst_n), .tx_clk_in(tclk), .sys_clk(sys_clk),
      .ref_clk(ref_clk), .rec_clk(rec_clk), .div_mode(div_mode), .div_sel(div_sel),
      .backup_sel(backup_sel), .force_sw(force_sw), .irq_en(irq_en), .irq_clr(irq_clr),
      .clk_out(clk_out), .status(status), .irq(irq));

   always @(posedge clk_out) if (counting) edge_cnt++;
   always @(clk_out) begin
      if (meas && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
      last_t = $realtime;
   end

   // {div_mode, div_sel, backup_sel, force_sw, tclk_run, sys_run, exp_src, exp_edges}
   localparam int NV = 14;
   localparam logic [15:0] VEC [0:NV-1] = '{
      {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 7'd24},  // R5 primary
      {1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 7'd17},  // R4 force ref
      {1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 7'd13},  // R4 force rec
      {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 7'd24},  // R5 return
      {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 7'd13},  // R3 loss to rec
      {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 7'd17},  // R3 loss to ref
      {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 7'd24},  // R5 recovered
      {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 7'd40},  // R6 /2
      {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 7'd20},  // R6 /4
      {1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 7'd10},  // R6 /8
      {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 7'd10},  // R6 code 11
      {1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 7'd13},  // R4 force in div mode
      {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 7'd17},  // R7 sys_clk loss
      {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 7'd24}   // R5 back to tx clock
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_near(input string req, input int act, input int exp);
      checks++;
      if (act < exp - 1 || act > exp + 1) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (+/-1)", req, act, exp);
      end
   endtask

   task automatic pulse_clr();
      @(negedge clk_mon) irq_clr = 1'b1;
      @(negedge clk_mon) irq_clr = 1'b0;
   endtask

   initial begin
      #150000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #21;
      chk("R12 status in reset", int'(status), 0);
      chk("R12 irq in reset", int'(irq), 0);
      @(negedge clk_mon) rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk_mon);
         {div_mode, div_sel, backup_sel, force_sw, tclk_run, sys_run} = VEC[k][15:9];
         #1500;
         chk($sformatf("R3/R4/R5/R6/R7 source vec %0d", k), int'(status[1:0]), int'(VEC[k][8:7]));
         edge_cnt = 0; counting = 1'b1;
         #480;
         counting = 1'b0;
         chk_near($sformatf("R3/R4/R6 edge rate vec %0d", k), edge_cnt, int'(VEC[k][6:0]));
      end

      // R8: clear, then primary loss sets the sticky flag
      pulse_clr();
      #4 chk("R8 cleared", int'(status[5]), 0);
      tclk_run = 1'b0;
      #80 chk("R1 not lost before limit", int'(status[2]), 0);
      #200;
      chk("R1 lost after limit", int'(status[2]), 1);
      chk("R8 flag set on loss", int'(status[5]), 1);
      chk("R9 irq enabled", int'(irq), 1);
      chk("R3 failover to ref", int'(status[1:0]), 1);
      tclk_run = 1'b1;
      #1500;
      chk("R2 lost cleared", int'(status[2]), 0);
      chk("R5 back on primary", int'(status[1:0]), 0);
      chk("R8 flag sticky", int'(status[5]), 1);
      @(negedge clk_mon) irq_en = 1'b0;
      #4 chk("R9 irq masked", int'(irq), 0);
      chk("R9 flag kept while masked", int'(status[5]), 1);
      @(negedge clk_mon) irq_en = 1'b1;
      #4 chk("R9 irq unmasked", int'(irq), 1);
      pulse_clr();
      #4 chk("R8 clear pulse", int'(irq), 0);

      // R10: forced switches among running clocks
      meas = 1'b1; min_w = 1.0e9;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk_mon) begin force_sw = ~force_sw; backup_sel = k[1]; end
         #400;
      end
      meas = 1'b0;
      chk("R10 no runt pulse", (min_w >= 9.99) ? 1 : 0, 1);
      @(negedge clk_mon) begin force_sw = 1'b0; backup_sel = 1'b0; end
      #600;

      // R11 / R8: backup loss flagged but no interrupt
      ref_run = 1'b0;
      #400;
      chk("R11 ref lost bit", int'(status[3]), 1);
      chk("R1 rec never lost", int'(status[4]), 0);
      chk("R11 primary bit clear", int'(status[2]), 0);
      chk("R8 backup loss no flag", int'(status[5]), 0);
      chk("R5 still on primary", int'(status[1:0]), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule